// File: doc/BRIEF.md
# Debug Watchpoint and Breakpoint Unit

This block watches the instruction fetch address, the address of load/store transfers and the data moved by them. It does this through eight programmable comparators. Four compare the instruction address, two compare the data-transfer address and two compare the data value. Each comparator holds a reference value and an operation: off, equal, unsigned less-than or unsigned greater-than. Comparators of one group are combined in pairs by a per-watchpoint select, which gives ranges (AND of a greater-than and a less-than) or alternatives (OR).

There are six watchpoints. Four are instruction watchpoints: watchpoints 0 and 1 draw on comparators 0/1, and watchpoints 2 and 3 draw on comparators 2/3. Two are data watchpoints, and each combines a data-address pair term with a data-value pair term. Every watchpoint event pulses its own output pin for one cycle. A per-watchpoint occurrence counter can turn every Nth event into a one-cycle breakpoint request. A simple single-cycle register write port configures the unit. Both outputs are registered and appear one clock after the bus cycle that caused them.

Top module: `dbg_watch_unit`

Register map (write-only, `cfg_addr`):

| Address | Content |
|---|---|
| 0..7 | reference value of comparator 0..7 (0-3 instruction address, 4-5 data address, 6-7 data value) |
| 8..15 | operation of comparator 0..7 in bits [1:0]: 0 off, 1 equal, 2 bus < ref, 3 bus > ref |
| 16..21 | select of watchpoint 0..5: bits [2:0] pair code; for data watchpoints bits [5:3] is the value pair code |
| 24..29 | break control of watchpoint 0..5: bits [15:0] count N, bit 16 break enable |

Pair code: 0 never, 1 first comparator, 2 second comparator, 3 both (AND), 4 either (OR), 5-7 never.

## Requirements
- R1: After reset all pins and break requests are low, every comparator is off and every select is 0, so no bus cycle produces an event until the unit is configured.
- R2: An instruction watchpoint event occurs only in a cycle with `ia_valid` high. Its pin bit is high in exactly the cycle after that bus cycle, and once for each event.
- R3: Less-than and greater-than compare the bus against the reference as unsigned 32-bit numbers.
- R4: A comparator whose operation is 0 never matches, whatever its reference, and a select code of 0 never produces an event.
- R5: Pair code 3 requires both comparators of the pair to match in the same cycle. Pair code 4 requires either of them. Codes 1 and 2 use a single comparator.
- R6: A data watchpoint event occurs only in a cycle with `dt_valid` high. When both its address code and its value code are non-zero, the address term and the value term must both hold in that same cycle. When only one code is non-zero, that term alone decides.
- R7: With break enabled and count N (N = 0 behaves as 1), the break bit goes high on the Nth event, one cycle after it and alongside the pin. The counter then reloads, so every Nth event breaks.
- R8: With break disabled a watchpoint still pulses its pin but never raises its break bit.
- R9: Writing a break control register restarts that watchpoint's count from the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| cfg_we | input | 1 | register write strobe |
| cfg_addr | input | 5 | register address |
| cfg_wdata | input | 32 | register write data |
| ia_valid | input | 1 | instruction address cycle valid |
| ia_addr | input | 32 | instruction effective address |
| dt_valid | input | 1 | data transfer cycle valid |
| dt_addr | input | 32 | data transfer effective address |
| dt_data | input | 32 | data transfer value |
| wp_pin | output | 6 | per-watchpoint event pulse |
| brk_req | output | 6 | per-watchpoint breakpoint request pulse |

## Verification
The bench uses references across bit 31, such as 0x8000_0000 against a less-than of 0x2000. A signed comparison would report a spurious watchpoint there. Data cycles where only the value or only the address matches would expose an OR where an AND is required, and data cycles with the valid strobe low would expose a missing qualifier. The count tests run the counter through a full reload, a zero count and a rewrite in mid-sequence. An off-by-one counter would break one event early or late, and a counter that fails to reload would stop breaking after the first time. A comparator that has a reference but is still switched off is checked too: decoding the operation wrongly at reset would give events before configuration.

// File: rtl/wdu_pkg.sv
package wdu_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {CMP_OFF = 2'd0, CMP_EQ = 2'd1, CMP_LT = 2'd2, CMP_GT = 2'd3} cmp_op_e;

  // register map bases (stride of 8 addresses per bank)
  localparam int A_REF = 0;
  localparam int A_OP  = 8;
  localparam int A_SEL = 16;
  localparam int A_BRK = 24;

  function automatic logic cmp_match(input cmp_op_e op, input logic [DATA_W-1:0] bus,
                                     input logic [DATA_W-1:0] refv);
    case (op)
      CMP_EQ:  return bus == refv;
      CMP_LT:  return bus < refv;
      CMP_GT:  return bus > refv;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic pair_term(input logic [2:0] code, input logic a, input logic b);
    case (code)
      3'd1:    return a;
      3'd2:    return b;
      3'd3:    return a & b;
      3'd4:    return a | b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic code_used(input logic [2:0] code);
    return (code >= 3'd1) && (code <= 3'd4);
  endfunction
endpackage

// File: rtl/wdu_comparator.sv
module wdu_comparator
  import wdu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ref,
  input  logic              wr_op,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] bus,
  output logic              hit
);
  logic [DATA_W-1:0] ref_q;
  cmp_op_e           op_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q <= '0;
      op_q  <= CMP_OFF;
    end else begin
      if (wr_ref) ref_q <= wdata;
      if (wr_op)  op_q  <= cmp_op_e'(wdata[1:0]);
    end
  end

  assign hit = cmp_match(op_q, bus, ref_q);

  // R4
  off_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_op && wdata[1:0] == 2'd0) |=> !hit);
endmodule

// File: rtl/wdu_counter.sv
module wdu_counter #(
  parameter int CNT_W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [CNT_W:0] load_val,
  input  logic           ev,
  output logic           brk
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, reload_q;
  logic             en_q, brk_q;
  logic [CNT_W-1:0] load_cnt;
  logic             fire;

  assign load_cnt = (load_val[CNT_W-1:0] == '0) ? ONE : load_val[CNT_W-1:0];
  assign fire     = ev && en_q && !load && (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= ONE;
      reload_q <= ONE;
      en_q     <= 1'b0;
      brk_q    <= 1'b0;
    end else begin
      brk_q <= fire;
      if (load) begin
        en_q     <= load_val[CNT_W];
        reload_q <= load_cnt;
        cnt_q    <= load_cnt;
      end else if (ev && en_q) begin
        cnt_q <= (cnt_q == ONE) ? reload_q : cnt_q - ONE;
      end
    end
  end

  assign brk = brk_q;

  // R7
  cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt_q != '0);
  // R7
  brk_reload_chk: assert property (@(posedge clk) disable iff (!rst_n) brk |-> cnt_q == reload_q);
  // R8
  brk_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n) brk |-> $past(en_q));
endmodule

// File: rtl/dbg_watch_unit.sv
module dbg_watch_unit
  import wdu_pkg::*;
#(
  parameter int N_IA  = 4,
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [4:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic        ia_valid,
  input  logic [31:0] ia_addr,
  input  logic        dt_valid,
  input  logic [31:0] dt_addr,
  input  logic [31:0] dt_data,
  output logic [5:0]  wp_pin,
  output logic [5:0]  brk_req
);
  localparam int N_DA  = 2;
  localparam int N_DV  = 2;
  localparam int N_CMP = N_IA + N_DA + N_DV;
  localparam int N_DWP = 2;
  localparam int N_WP  = N_IA + N_DWP;
  localparam int DA0   = N_IA;
  localparam int DV0   = N_IA + N_DA;

  logic [N_CMP-1:0] hit;
  logic [N_WP-1:0]  ev;
  logic [N_WP-1:0]  pin_q;
  logic [N_WP-1:0]  brk_w;
  logic [2:0]       sel_q  [N_WP];
  logic [2:0]       vsel_q [N_DWP];

  // comparators
  for (genvar c = 0; c < N_CMP; c++) begin : g_cmp
    logic [DATA_W-1:0] bus;
    if (c < DA0)      begin : g_i assign bus = ia_addr; end
    else if (c < DV0) begin : g_a assign bus = dt_addr; end
    else              begin : g_v assign bus = dt_data; end
    wdu_comparator u_cmp (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_ref(cfg_we && cfg_addr == 5'(A_REF + c)),
      .wr_op (cfg_we && cfg_addr == 5'(A_OP + c)),
      .wdata (cfg_wdata),
      .bus   (bus),
      .hit   (hit[c])
    );
  end

  // per-watchpoint select and event
  for (genvar w = 0; w < N_WP; w++) begin : g_wp
    logic sel_wr;
    assign sel_wr = cfg_we && cfg_addr == 5'(A_SEL + w);
    always_ff @(posedge clk) begin
      if (!rst_n)      sel_q[w] <= '0;
      else if (sel_wr) sel_q[w] <= cfg_wdata[2:0];
    end

    if (w < N_IA) begin : g_iwp
      localparam int PB = (w / 2) * 2;
      assign ev[w] = ia_valid && pair_term(sel_q[w], hit[PB], hit[PB+1]);
      // R2
      instr_pin_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_q[w] |-> $past(ia_valid));
    end else begin : g_dwp
      localparam int K = w - N_IA;
      logic a_on, v_on, a_t, v_t;
      always_ff @(posedge clk) begin
        if (!rst_n)      vsel_q[K] <= '0;
        else if (sel_wr) vsel_q[K] <= cfg_wdata[5:3];
      end
      assign a_on  = code_used(sel_q[w]);
      assign v_on  = code_used(vsel_q[K]);
      assign a_t   = pair_term(sel_q[w],  hit[DA0], hit[DA0+1]);
      assign v_t   = pair_term(vsel_q[K], hit[DV0], hit[DV0+1]);
      assign ev[w] = dt_valid && (a_on || v_on) && (!a_on || a_t) && (!v_on || v_t);
      // R6
      data_pin_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_q[w] |-> $past(dt_valid));
    end

    wdu_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (cfg_we && cfg_addr == 5'(A_BRK + w)),
      .load_val(cfg_wdata[CNT_W:0]),
      .ev      (ev[w]),
      .brk     (brk_w[w])
    );

    // R7
    brk_with_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brk_w[w] |-> pin_q[w]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= ev;
  end

  assign wp_pin  = pin_q;
  assign brk_req = brk_w;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) $past(!rst_n) |-> (wp_pin == '0 && brk_req == '0));
endmodule

// File: tb/test_dbg_watch_unit.sv
module test_dbg_watch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        ia_valid = 1'b0;
  logic [31:0] ia_addr = '0;
  logic        dt_valid = 1'b0;
  logic [31:0] dt_addr = '0;
  logic [31:0] dt_data = '0;
  logic [5:0]  wp_pin, brk_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dbg_watch_unit i_dbg_watch_unit (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ia_valid(ia_valid), .ia_addr(ia_addr), .dt_valid(dt_valid), .dt_addr(dt_addr),
    .dt_data(dt_data), .wp_pin(wp_pin), .brk_req(brk_req)
  );

  // fields: ia, ia_valid, dt_addr, dt_data, dt_valid, expected pins, expected breaks
  localparam int NV = 12;
  localparam logic [109:0] VEC [NV] = '{
    {32'h0000_1800, 1'b1, 32'h0, 32'h0, 1'b0, 6'b000011, 6'b000000}, // R5 range+single, R8
    {32'h0000_1000, 1'b1, 32'h0, 32'h0, 1'b0, 6'b000010, 6'b000000}, // R3 GT boundary
    {32'h0000_1800, 1'b0, 32'h0, 32'h0, 1'b0, 6'b000000, 6'b000000}, // R2 no valid
    {32'h8000_0000, 1'b1, 32'h0, 32'h0, 1'b0, 6'b001100, 6'b000000}, // R3 unsigned, R5 OR
    {32'h7FFF_FFFF, 1'b1, 32'h0, 32'h0, 1'b0, 6'b000000, 6'b000000}, // R3
    {32'hFFFF_FFFF, 1'b1, 32'h0, 32'h0, 1'b0, 6'b000000, 6'b000000}, // R4 off comparator
    {32'h0, 1'b0, 32'h0000_0400, 32'h0000_0100, 1'b1, 6'b110000, 6'b000000}, // R6 both
    {32'h0, 1'b0, 32'h0000_0400, 32'h0000_00FF, 1'b1, 6'b000000, 6'b000000}, // R6 addr only
    {32'h0, 1'b0, 32'h0000_0404, 32'h0000_0200, 1'b1, 6'b100000, 6'b000000}, // R6 value only
    {32'h0, 1'b0, 32'h0000_0400, 32'h0000_0200, 1'b0, 6'b000000, 6'b000000}, // R6 no valid
    {32'h0000_1800, 1'b1, 32'h0000_0400, 32'h0000_0100, 1'b1, 6'b110011, 6'b000000}, // R2 R6
    {32'h0000_1FFF, 1'b1, 32'h0, 32'h0, 1'b0, 6'b000011, 6'b000001}  // R7 third event
  };

  task automatic chk(input string req, input string what, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // called at a negedge, returns at the next negedge
  task automatic wr(input int a, input logic [31:0] d);
    ia_valid = 1'b0; dt_valid = 1'b0;
    cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cyc(input logic [31:0] ia, input logic iv, input logic [31:0] da,
                     input logic [31:0] dd, input logic dv);
    ia_addr = ia; ia_valid = iv; dt_addr = da; dt_data = dd; dt_valid = dv;
    @(negedge clk);
  endtask

  task automatic idle();
    ia_valid = 1'b0; dt_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "pins in reset", wp_pin, 6'b0);
    chk("R1", "breaks in reset", brk_req, 6'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "pins after reset", wp_pin, 6'b0);
    // select set but comparators still off, reference 0
    wr(16, 32'd4);
    cyc(32'h0, 1'b1, 32'h0, 32'h0, 1'b1);
    chk("R1", "unconfigured comparator pins", wp_pin, 6'b0);
    chk("R1", "unconfigured comparator breaks", brk_req, 6'b0);

    // comparators: op 1 eq, 2 lt, 3 gt
    wr(0, 32'h0000_1000); wr(8, 32'd3);
    wr(1, 32'h0000_2000); wr(9, 32'd2);
    wr(2, 32'h8000_0000); wr(10, 32'd1);
    wr(3, 32'hFFFF_FFF0);                 // operation left off (R4)
    wr(4, 32'h0000_0400); wr(12, 32'd1);
    wr(6, 32'h0000_00FF); wr(14, 32'd3);
    // selects
    wr(16, 32'd3); wr(17, 32'd2); wr(18, 32'd1); wr(19, 32'd4);
    wr(20, 32'h9); wr(21, 32'h8);
    // break on every third event of watchpoint 0
    wr(24, 32'h0001_0003);

    for (int i = 0; i < NV; i++) begin
      logic [109:0] v;
      v = VEC[i];
      cyc(v[109:78], v[77], v[76:45], v[44:13], v[12]);
      chk("R2/R3/R5/R6", $sformatf("vector %0d pins", i), wp_pin, v[11:6]);
      chk("R7/R8", $sformatf("vector %0d breaks", i), brk_req, v[5:0]);
    end
    idle();
    chk("R2", "pin is one cycle wide", wp_pin, 6'b0);

    // R7: reload after firing, next break on third event again
    cyc(32'h1800, 1'b1, 32'h0, 32'h0, 1'b0);
    chk("R7", "reload event 1", brk_req, 6'b0);
    cyc(32'h1800, 1'b1, 32'h0, 32'h0, 1'b0);
    chk("R7", "reload event 2", brk_req, 6'b0);
    cyc(32'h1800, 1'b1, 32'h0, 32'h0, 1'b0);
    chk("R7", "reload event 3", brk_req, 6'b000001);
    chk("R2", "pins with break", wp_pin, 6'b000011);

    // R9: rewrite restarts the count
    wr(24, 32'h0001_0002);
    cyc(32'h1800, 1'b1, 32'h0, 32'h0, 1'b0);
    chk("R9", "first of two", brk_req, 6'b0);
    wr(24, 32'h0001_0002);
    cyc(32'h1800, 1'b1, 32'h0, 32'h0, 1'b0);
    chk("R9", "restarted first", brk_req, 6'b0);
    cyc(32'h1800, 1'b1, 32'h0, 32'h0, 1'b0);
    chk("R9", "restarted second", brk_req, 6'b000001);

    // R7: count 0 acts as 1, every event breaks; back-to-back pulses
    wr(26, 32'h0001_0000);
    cyc(32'h8000_0000, 1'b1, 32'h0, 32'h0, 1'b0);
    chk("R7", "count zero first", brk_req, 6'b000100);
    cyc(32'h8000_0000, 1'b1, 32'h0, 32'h0, 1'b0);
    chk("R7", "count zero second", brk_req, 6'b000100);
    chk("R2", "back-to-back pins", wp_pin, 6'b001100);

    // R4: enabling the comparator that held a reference
    wr(11, 32'd3);
    cyc(32'hFFFF_FFFF, 1'b1, 32'h0, 32'h0, 1'b0);
    chk("R4", "enabled comparator 3", wp_pin, 6'b001000);
    // R4: select code 0 silences watchpoint 1
    wr(17, 32'd0);
    cyc(32'h1800, 1'b1, 32'h0, 32'h0, 1'b0);
    chk("R4", "select zero", wp_pin, 6'b000001);
    chk("R9", "count after restart", brk_req, 6'b0);
    idle();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule